// File: doc/BRIEF.md
# Security Attribution and Access Checker

This block decides, for each address the CPU presents, whether the location is Secure, Non-Secure or Non-Secure-Callable. Two sources feed the decision. A fixed rule looks at address bit 28 alone. A bank of eight programmable windows can open address ranges to the Non-Secure world, or mark them as callable entry areas. The result always takes the more secure of the two verdicts.

The same cycle also judges the access itself. The inputs are the access type (instruction fetch or data), the CPU's current security state and a flag that says whether the fetched opcode is a secure-gateway instruction. The block flags a secure fault when Non-Secure code reaches into Secure memory. It grants a state change to Secure when Non-Secure code fetches a gateway opcode from a callable area.

Requests enter on a valid/ready channel and verdicts leave on a valid/ready channel, through a single output register. A verdict appears on the clock after its request is accepted. While the consumer holds `rsp_ready` low, the verdict stays frozen and `req_ready` drops, so requests back up into the producer and none are lost. The window bank is programmed through a plain write port that has a select field. A lock bit freezes the bank until reset.

Top module: `sec_attr_check`

## Requirements
- R1: When address bit 28 is 1 the attribute is Secure (`rsp_attr` = 2), whatever the windows say.
- R2: When address bit 28 is 0 and no enabled window covers the address, the attribute is Secure.
- R3: When address bit 28 is 0 and exactly one enabled window covers the address, the attribute comes from that window. A window with its callable flag clear gives Non-Secure (0), and one with the flag set gives Non-Secure-Callable (1). A window covers addresses from base[31:5]·00000 through limit[31:5]·11111 inclusive. Code 3 never appears.
- R4: When two or more enabled windows cover an address, the attribute is Secure.
- R5: Config writes (`cfg_we` = 1) select a target with `cfg_sel`. Select 0 loads the window number from wdata[2:0]. Select 1 loads that window's base from wdata[31:5]. Select 2 loads its limit from wdata[31:5], its callable flag from wdata[1] and its enable from wdata[0]. There are 8 windows.
- R6: A write with select 3 and wdata[0] = 1 sets the lock. The lock stays set until reset, and every later window write is ignored.
- R7: In Non-Secure state, a data access to a Secure or Callable address raises `rsp_fault`.
- R8: In Non-Secure state, a fetch from a Secure address faults, and a fetch from a Non-Secure address does not.
- R9: In Non-Secure state, a fetch from a Callable address with `req_gateway` = 1 does not fault and sets `rsp_enter_secure`. With `req_gateway` = 0 it faults.
- R10: In Secure state no access faults and `rsp_enter_secure` stays 0.
- R11: `req_ready` = !rsp_valid || rsp_ready. An accepted request yields `rsp_valid` on the next clock. While `rsp_valid` is 1 and `rsp_ready` is 0 the verdict holds unchanged.
- R12: After reset `rsp_valid` is 0, the lock is clear and all windows are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 2 | Config target: 0 number, 1 base, 2 limit/flags, 3 lock |
| cfg_wdata | input | 32 | Config write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_addr | input | 32 | Access address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_secure | input | 1 | CPU is in Secure state |
| req_gateway | input | 1 | Fetched opcode is a secure-gateway instruction |
| rsp_valid | output | 1 | Verdict valid |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_attr | output | 2 | 0 Non-Secure, 1 Callable, 2 Secure |
| rsp_fault | output | 1 | Secure fault |
| rsp_enter_secure | output | 1 | Legal gateway fetch: switch to Secure |

## Verification
Addresses probe the exact base and limit granules of a window and the granule just outside each end. The base is written with nonzero low bits, which exposes any comparison that uses the full address instead of the 32-byte granule. The same offsets are repeated with bit 28 set, overlapping windows are created and then removed, and a window is disabled in place, so the bit-28 rule, the overlap rule and the enable bit each have their own failing case. Every mix of state, access type and gateway flag is applied to each of the three attributes. Stalls of several cycles on the response side, with a second request waiting, show whether a verdict is held or lost.

// File: rtl/secattr_pkg.sv
package secattr_pkg;
  localparam int SA_AW   = 32;
  localparam int SA_GB   = 5;
  localparam int SA_HIW  = SA_AW - SA_GB;

  typedef enum logic [1:0] {
    SA_NS  = 2'd0,
    SA_NSC = 2'd1,
    SA_S   = 2'd2
  } sa_attr_e;

  typedef enum logic [1:0] {
    CFG_RNUM  = 2'd0,
    CFG_BASE  = 2'd1,
    CFG_LIMIT = 2'd2,
    CFG_LOCK  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [SA_HIW-1:0] base;
    logic [SA_HIW-1:0] limit;
    logic              nsc;
    logic              en;
  } window_t;
endpackage

// File: rtl/secattr_regs.sv
module secattr_regs
  import secattr_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AW   = SA_AW,
  parameter int GB   = SA_GB
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_sel,
  input  logic [AW-1:0]         cfg_wdata,
  output window_t [NWIN-1:0]    win_o,
  output logic                  lock_o
);
  localparam int IW = (NWIN > 1) ? $clog2(NWIN) : 1;

  logic [IW-1:0]       rnum_q;
  window_t [NWIN-1:0]  win_q;
  logic                lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rnum_q <= '0;
      lock_q <= 1'b0;
      for (int i = 0; i < NWIN; i++) win_q[i] <= '0;
    end else if (cfg_we && !lock_q) begin
      unique case (cfg_sel_e'(cfg_sel))
        CFG_RNUM: rnum_q <= cfg_wdata[IW-1:0];
        CFG_BASE: begin
          if (32'(rnum_q) < NWIN) win_q[rnum_q].base <= cfg_wdata[AW-1:GB];
        end
        CFG_LIMIT: begin
          if (32'(rnum_q) < NWIN) begin
            win_q[rnum_q].limit <= cfg_wdata[AW-1:GB];
            win_q[rnum_q].nsc   <= cfg_wdata[1];
            win_q[rnum_q].en    <= cfg_wdata[0];
          end
        end
        CFG_LOCK: if (cfg_wdata[0]) lock_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign win_o  = win_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/secattr_match.sv
module secattr_match
  import secattr_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AW   = SA_AW,
  parameter int GB   = SA_GB
) (
  input  logic [AW-1:0]       addr,
  input  window_t [NWIN-1:0]  win,
  output logic [NWIN-1:0]     hit,
  output logic [NWIN-1:0]     nsc
);
  logic [AW-GB-1:0] granule;
  assign granule = addr[AW-1:GB];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign hit[g] = win[g].en &&
                    (granule >= win[g].base) &&
                    (granule <= win[g].limit);
    assign nsc[g] = win[g].nsc;
  end
endmodule

// File: rtl/secattr_judge.sv
module secattr_judge
  import secattr_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  logic            fixed_secure,
  input  logic [NWIN-1:0] hit,
  input  logic [NWIN-1:0] nsc,
  input  logic            is_fetch,
  input  logic            cpu_secure,
  input  logic            gateway,
  output sa_attr_e        attr,
  output logic            fault,
  output logic            enter_secure
);
  localparam int CW = $clog2(NWIN + 1);

  logic [CW-1:0] nhits;
  logic          hit_nsc;

  always_comb begin
    nhits = '0;
    for (int i = 0; i < NWIN; i++) nhits = nhits + CW'(hit[i]);
  end
  assign hit_nsc = |(hit & nsc);

  always_comb begin
    if (fixed_secure || nhits != CW'(1)) attr = SA_S;
    else if (hit_nsc)                    attr = SA_NSC;
    else                                 attr = SA_NS;
  end

  always_comb begin
    fault        = 1'b0;
    enter_secure = 1'b0;
    if (!cpu_secure) begin
      if (!is_fetch) begin
        fault = (attr != SA_NS);
      end else begin
        unique case (attr)
          SA_S:    fault = 1'b1;
          SA_NSC: begin
            fault        = !gateway;
            enter_secure = gateway;
          end
          default: fault = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sec_attr_check.sv
module sec_attr_check
  import secattr_pkg::*;
#(
  parameter int NWIN      = 8,
  parameter int AW        = SA_AW,
  parameter int GB        = SA_GB,
  parameter int FIXED_BIT = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_fetch,
  input  logic          req_secure,
  input  logic          req_gateway,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [1:0]    rsp_attr,
  output logic          rsp_fault,
  output logic          rsp_enter_secure
);
  window_t [NWIN-1:0] win_w;
  logic               lock_w;
  logic [NWIN-1:0]    hit_w;
  logic [NWIN-1:0]    nsc_w;
  sa_attr_e           attr_w;
  logic               fault_w;
  logic               enter_w;
  logic               accept;

  secattr_regs #(.NWIN(NWIN), .AW(AW), .GB(GB)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .win_o(win_w), .lock_o(lock_w)
  );

  secattr_match #(.NWIN(NWIN), .AW(AW), .GB(GB)) u_match (
    .addr(req_addr), .win(win_w), .hit(hit_w), .nsc(nsc_w)
  );

  secattr_judge #(.NWIN(NWIN)) u_judge (
    .fixed_secure(req_addr[FIXED_BIT]), .hit(hit_w), .nsc(nsc_w),
    .is_fetch(req_fetch), .cpu_secure(req_secure), .gateway(req_gateway),
    .attr(attr_w), .fault(fault_w), .enter_secure(enter_w)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid        <= 1'b0;
      rsp_attr         <= 2'd0;
      rsp_fault        <= 1'b0;
      rsp_enter_secure <= 1'b0;
    end else if (accept) begin
      rsp_valid        <= 1'b1;
      rsp_attr         <= attr_w;
      rsp_fault        <= fault_w;
      rsp_enter_secure <= enter_w;
    end else if (rsp_ready) begin
      rsp_valid        <= 1'b0;
    end
  end
endmodule

// File: rtl/secattr_chk.sv
module secattr_chk
  import secattr_pkg::*;
#(
  parameter int NWIN      = 8,
  parameter int AW        = SA_AW,
  parameter int FIXED_BIT = 28
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [AW-1:0]      req_addr,
  input logic               req_fetch,
  input logic               req_secure,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [1:0]         rsp_attr,
  input logic               rsp_fault,
  input logic               rsp_enter_secure,
  input logic               lock,
  input window_t [NWIN-1:0] win
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_fixed_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_addr[FIXED_BIT] |=> rsp_attr == SA_S);

  assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_attr != 2'd3);

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);

  assert_lock_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(win));

  assert_ns_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_secure && !req_fetch |=> rsp_fault == (rsp_attr != SA_NS));

  assert_gateway_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_enter_secure |-> !rsp_fault && rsp_attr == SA_NSC);

  assert_secure_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_secure |=> !rsp_fault && !rsp_enter_secure);

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_attr) &&
                                $stable(rsp_fault) && $stable(rsp_enter_secure));
endmodule

bind sec_attr_check secattr_chk #(.NWIN(NWIN), .AW(AW), .FIXED_BIT(FIXED_BIT)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_fetch(req_fetch), .req_secure(req_secure),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_attr(rsp_attr),
  .rsp_fault(rsp_fault), .rsp_enter_secure(rsp_enter_secure),
  .lock(lock_w), .win(win_w)
);

// File: tb/test_sec_attr_check.sv
`timescale 1ns/1ps
module test_sec_attr_check;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_addr = 0;
  logic        req_fetch = 0;
  logic        req_secure = 0;
  logic        req_gateway = 0;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic [1:0]  rsp_attr;
  logic        rsp_fault;
  logic        rsp_enter_secure;

  int checks = 0;
  int errors = 0;
  string tag = "R12";
  bit done = 0;

  always #4 clk = ~clk;

  sec_attr_check i_sec_attr_check (.*);

  // behavioural reference model
  logic [31:0] mb [8];
  logic [31:0] ml [8];
  bit mn [8];
  bit me [8];
  int mr;
  bit mlock;
  bit m_valid;
  int m_attr;
  bit m_fault, m_enter;

  function automatic int ref_attr(logic [31:0] a);
    int cnt = 0;
    int k = 0;
    if (a[28]) return 2;
    for (int i = 0; i < 8; i++)
      if (me[i] && a >= mb[i] && a <= ml[i]) begin cnt++; k = i; end
    if (cnt != 1) return 2;
    return mn[k] ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; mlock = 0; mr = 0;
      for (int i = 0; i < 8; i++) begin mb[i] = 0; ml[i] = 32'h1f; mn[i] = 0; me[i] = 0; end
    end else begin
      if (req_valid && (!m_valid || rsp_ready)) begin
        int a;
        a = ref_attr(req_addr);
        m_attr = a; m_fault = 0; m_enter = 0;
        if (!req_secure) begin
          if (!req_fetch) m_fault = (a != 0);
          else if (a == 2) m_fault = 1;
          else if (a == 1) begin m_fault = !req_gateway; m_enter = req_gateway; end
        end
        m_valid = 1;
      end else if (rsp_ready) m_valid = 0;
      if (cfg_we && !mlock) begin
        case (cfg_sel)
          2'd0: mr = int'(cfg_wdata[2:0]);
          2'd1: mb[mr] = cfg_wdata & ~32'h1f;
          2'd2: begin ml[mr] = cfg_wdata | 32'h1f; mn[mr] = cfg_wdata[1]; me[mr] = cfg_wdata[0]; end
          default: if (cfg_wdata[0]) mlock = 1;
        endcase
      end
    end
  end

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    if (!rst_n) chk("R12", "rsp_valid in reset", int'(rsp_valid), 0);
    else begin
      chk(tag, "rsp_valid", int'(rsp_valid), int'(m_valid));
      chk("R11", "req_ready", int'(req_ready), int'(!m_valid || rsp_ready));
      if (m_valid) begin
        chk(tag, "rsp_attr", int'(rsp_attr), m_attr);
        chk(tag, "rsp_fault", int'(rsp_fault), int'(m_fault));
        chk(tag, "rsp_enter_secure", int'(rsp_enter_secure), int'(m_enter));
      end
    end
  end

  task automatic cfg(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic win(int n, logic [31:0] b, logic [31:0] l, bit nsc, bit en);
    cfg(2'd0, 32'(n));
    cfg(2'd1, b);
    cfg(2'd2, {l[31:2], nsc, en});
  endtask

  task automatic acc(logic [31:0] a, bit f, bit s, bit g);
    bit r;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_fetch = f; req_secure = s; req_gateway = g;
    forever begin
      r = req_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R2";
    acc(32'h0010_0000, 0, 0, 0);           // unmapped: Secure, data faults (R7)
    tag = "R5";
    win(0, 32'h0010_0013, 32'h0010_FFE0, 0, 1);
    tag = "R3";
    acc(32'h0010_0000, 0, 0, 0);
    acc(32'h0010_FFFF, 0, 0, 0);
    acc(32'h0011_0000, 0, 0, 0);
    acc(32'h000F_FFFF, 0, 0, 0);
    tag = "R1";
    win(1, 32'h1000_0000, 32'h1FFF_FFE0, 0, 1);
    acc(32'h1010_0000, 0, 0, 0);
    acc(32'h1010_0000, 1, 0, 0);
    tag = "R9";
    win(2, 32'h0020_0000, 32'h0020_0FE0, 1, 1);
    acc(32'h0020_0000, 1, 0, 1);
    acc(32'h0020_0FFC, 1, 0, 0);
    tag = "R7";
    acc(32'h0020_0010, 0, 0, 1);
    acc(32'h3000_0000, 0, 0, 0);
    tag = "R8";
    acc(32'h0010_0040, 1, 0, 0);
    acc(32'h0030_0000, 1, 0, 1);
    tag = "R10";
    acc(32'h0030_0000, 0, 1, 0);
    acc(32'h0020_0000, 1, 1, 1);
    acc(32'h0010_0000, 1, 1, 0);
    tag = "R4";
    win(3, 32'h0010_8000, 32'h0010_80E0, 0, 1);
    acc(32'h0010_8000, 0, 0, 0);
    acc(32'h0010_7FFF, 0, 0, 0);
    cfg(2'd2, 32'h0010_80E0);               // disable window 3 in place
    acc(32'h0010_8000, 0, 0, 0);
    tag = "R11";
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_addr = 32'h0020_0000; req_fetch = 1; req_secure = 0; req_gateway = 1;
    @(negedge clk);
    req_addr = 32'h0030_0000; req_fetch = 0;
    repeat (4) @(negedge clk);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);
    tag = "R6";
    cfg(2'd3, 32'h1);
    win(0, 32'h0000_0000, 32'h0000_0000, 1, 0);
    cfg(2'd3, 32'h0);
    acc(32'h0010_0000, 0, 0, 0);
    acc(32'h0000_0000, 1, 0, 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule